// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the control and status register file for one 32-pin general-purpose I/O port. A processor reaches it over a plain synchronous register bus: an address, a write strobe and write data on one side, and read data on the other. The bank stores the settings that steer each pin: whether it is a GPIO or an alternate function, which alternate function, whether the output driver is on, and the driven value. It also stores the interrupt configuration (mode, polarity, dual-edge select, input enable), the interrupt and wake enables, and a set of plain pad-setting words. All of these appear as parallel outputs for the pad muxing, the output drivers and a separate edge-detector block.

Seven of the control registers have two alias addresses next to the base address. A write to the first alias sets the bits given as 1. A write to the second alias clears the bits given as 1. Bits given as 0 keep their value, so software can change single pins without a read-modify-write. The bank also returns the pin levels through a two-stage synchronizer. It holds the sticky pending-interrupt flags that the external detector raises through `irq_hit`. Software clears those flags by writing 1s to a clear address.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, `func_en` is all ones. Every other stored register, every output word and every interrupt flag is zero.
- R2: A write to a base address loads the whole data word at the next rising clock edge. `bus_rdata` shows the addressed register without delay, in the same cycle as the address. Base addresses with aliases: function enable 0x00, output enable 0x0C, output value 0x18, interrupt enable 0x34, wake enable 0x4C, first alternate select 0x68, second alternate select 0x74.
- R3: A write to base+4 of an aliased register sets each bit that is 1 in the data word and leaves the other bits unchanged.
- R4: A write to base+8 of an aliased register clears each bit that is 1 in the data word and leaves the other bits unchanged.
- R5: A read of either alias address returns the current value of its base register.
- R6: A read of 0x24 returns `pin_in` delayed by two rising clock edges. Writes to 0x24 change nothing.
- R7: A bit of `irq_hit` that is high at a clock edge sets the same flag bit. The flag then stays set until a write to 0x48 carries a 1 in that bit. If a hit and a clear arrive for a bit in the same cycle, the hit wins. Reads of 0x40 and 0x48 return the flags. Writes to 0x40 change nothing.
- R8: Plain read/write words have no aliases. They are interrupt mode 0x28, polarity 0x2C, input enable 0x30, dual-edge select 0x5C, and pad settings at 0x60, 0x64, 0xA8, 0xAC, 0xB0, 0xB4, 0xB8 and 0xC0. The pad words appear on `pad_cfg` in that address order, with the lowest address in bits 31:0.
- R9: Reserved, unmapped and misaligned addresses read as zero. A write to any of them changes no register and no output. A misaligned address is one with `bus_addr[1:0]` not zero.
- R10: Each register drives its own output word, and a write to one address changes no other register. The output words are `func_en`, `out_en`, `out_val`, `int_en`, `wake_en`, `alt1_sel`, `alt2_sel`, `int_mode`, `int_pol`, `in_en`, `int_dual` and `int_flags`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Raw pin levels |
| irq_hit | input | 32 | Per-pin event pulses from the edge detector |
| func_en | output | 32 | 1 = GPIO, 0 = alternate function |
| alt1_sel | output | 32 | First alternate-function select (0 primary, 1 secondary) |
| alt2_sel | output | 32 | Second alternate-function select |
| out_en | output | 32 | Output driver enable |
| out_val | output | 32 | Driven output value |
| int_mode | output | 32 | Interrupt mode per pin |
| int_pol | output | 32 | Interrupt polarity per pin |
| int_dual | output | 32 | Dual-edge select per pin |
| in_en | output | 32 | Input enable per pin |
| int_en | output | 32 | Interrupt enable per pin |
| wake_en | output | 32 | Wake enable per pin |
| int_flags | output | 32 | Pending interrupt flags |
| pad_cfg | output | 256 | Eight pad-setting words, lowest address in the lowest slice |

## Verification
On every cycle the assertions check the following. The output-enable set and clear aliases combine with the previous value. A write to another register's alias leaves the output enable untouched. A read of an alias shows its base register, and reserved words read zero. Pending flags never drop without a clear write, and a hit always lands in the flags. Once two cycles have passed since reset, a pin read shows the input from two edges earlier. The bench scenarios cover the reset values and every aliased and plain register, with mixed random traffic across mapped, reserved and misaligned addresses. They also cover the pad-word ordering on `pad_cfg`, the hit-over-clear collision, and the exact cycle at which a pin change becomes visible.

// File: rtl/gpio_regs_pkg.sv
// Package: address map and register-bank layout for the GPIO port registers.
// Assumes a 32-bit data word and word-aligned byte addresses (index = addr/4).
package gpio_regs_pkg;

    localparam int PORT_W = 32;

    // Registers with set and clear aliases at word index +1 and +2.
    localparam int NUM_SC   = 7;
    localparam int SC_FUNC  = 0;
    localparam int SC_OE    = 1;
    localparam int SC_OUT   = 2;
    localparam int SC_IEN   = 3;
    localparam int SC_WAKE  = 4;
    localparam int SC_ALT1  = 5;
    localparam int SC_ALT2  = 6;
    localparam int SC_BASE [NUM_SC] = '{0, 3, 6, 13, 19, 26, 29};

    // Plain read/write words.
    localparam int NUM_PL   = 12;
    localparam int PL_MODE  = 0;
    localparam int PL_POL   = 1;
    localparam int PL_INEN  = 2;
    localparam int PL_DUAL  = 3;
    localparam int PL_PAD0  = 4;
    localparam int NUM_PAD  = NUM_PL - PL_PAD0;
    localparam int PL_BASE [NUM_PL] = '{10, 11, 12, 23, 24, 25, 42, 43, 44, 45, 46, 48};

    // Read-only and special words.
    localparam int IDX_PIN     = 9;
    localparam int IDX_FLAG    = 16;
    localparam int IDX_FLAGCLR = 18;

    typedef logic [PORT_W-1:0] port_word_t;

endpackage

// File: rtl/gpio_setclr_reg.sv
// Module: one register word with an optional pair of write-one-to-set and
// write-one-to-clear strobes. Assumes at most one strobe is active per cycle.
module gpio_setclr_reg #(
    parameter int          W         = 32,
    parameter logic [W-1:0] RST_VAL  = '0,
    parameter bit          HAS_ALIAS = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_base,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;
    logic [W-1:0] q_nxt;

    // Build the per-bit set and clear masks from the alias strobes.
    always_comb begin
        set_m = (HAS_ALIAS && wr_set) ? wdata : '0;
        clr_m = (HAS_ALIAS && wr_clr) ? wdata : '0;
    end

    // Next value: full load on a base write, else masked set then clear.
    always_comb begin
        if (wr_base) q_nxt = wdata;
        else         q_nxt = (q | set_m) & ~clr_m;
    end

    // State register with synchronous reset to the configured value.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= q_nxt;
    end
endmodule

// File: rtl/gpio_pin_sync.sv
// Module: two-flop synchronizer for the raw pin levels.
// Assumes each pin is an independent bit; no cross-bit coherence is offered.
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two stages in series; both reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_irq_flags.sv
// Module: sticky pending-interrupt flags. Set by detector pulses, cleared by
// write-one-to-clear. Assumes a pulse in the clear cycle should not be lost.
module gpio_irq_flags #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hit,
    input  logic         clr_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flags
);
    logic [W-1:0] clr_m;

    // Clear mask is only active on a write to the clear address.
    always_comb clr_m = clr_wr ? wdata : '0;

    // Clear first, then OR in new hits so a same-cycle hit wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_m) | hit;
    end
endmodule

// File: rtl/gpio_read_mux.sv
// Module: combinational read-data selection over the word index.
// Assumes alias words return their base register and holes return zero.
module gpio_read_mux
    import gpio_regs_pkg::*;
#(
    parameter int WORD_W = 6
) (
    input  logic                           aligned,
    input  logic [WORD_W-1:0]              word,
    input  logic [NUM_SC-1:0][PORT_W-1:0]  sc_q,
    input  logic [NUM_PL-1:0][PORT_W-1:0]  pl_q,
    input  port_word_t                     pin_q,
    input  port_word_t                     flags,
    output port_word_t                     rdata
);
    // Compare the word index against every mapped location; default zero.
    always_comb begin
        rdata = '0;
        if (aligned) begin
            for (int i = 0; i < NUM_SC; i++) begin
                if (int'(word) >= SC_BASE[i] && int'(word) <= SC_BASE[i] + 2)
                    rdata = sc_q[i];
            end
            for (int j = 0; j < NUM_PL; j++) begin
                if (int'(word) == PL_BASE[j])
                    rdata = pl_q[j];
            end
            if (int'(word) == IDX_PIN)
                rdata = pin_q;
            if (int'(word) == IDX_FLAG || int'(word) == IDX_FLAGCLR)
                rdata = flags;
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
// Module: GPIO port register bank top. Decodes the register bus, holds the
// aliased and plain control words, synchronizes pins and keeps pending flags.
// Assumes one access per cycle; reads are combinational, writes land at the edge.
module gpio_port_regs
    import gpio_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [31:0]             pin_in,
    input  logic [31:0]             irq_hit,
    output logic [31:0]             func_en,
    output logic [31:0]             alt1_sel,
    output logic [31:0]             alt2_sel,
    output logic [31:0]             out_en,
    output logic [31:0]             out_val,
    output logic [31:0]             int_mode,
    output logic [31:0]             int_pol,
    output logic [31:0]             int_dual,
    output logic [31:0]             in_en,
    output logic [31:0]             int_en,
    output logic [31:0]             wake_en,
    output logic [31:0]             int_flags,
    output logic [NUM_PAD*32-1:0]   pad_cfg
);
    localparam int WORD_W = ADDR_W - 2;

    logic                          aligned;
    logic [WORD_W-1:0]             word;
    logic                          wr_ok;
    logic [NUM_SC-1:0][PORT_W-1:0] sc_q;
    logic [NUM_PL-1:0][PORT_W-1:0] pl_q;
    port_word_t                    pin_q;
    port_word_t                    flags_q;
    logic                          flag_clr_wr;

    // Address split: word index plus alignment check.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        word    = bus_addr[ADDR_W-1:2];
        wr_ok   = bus_wr && aligned;
    end

    // Aliased control words; the function enable resets to all ones.
    for (genvar i = 0; i < NUM_SC; i++) begin : g_sc
        logic hit_base, hit_set, hit_clr;
        always_comb begin
            hit_base = wr_ok && (int'(word) == SC_BASE[i]);
            hit_set  = wr_ok && (int'(word) == SC_BASE[i] + 1);
            hit_clr  = wr_ok && (int'(word) == SC_BASE[i] + 2);
        end
        gpio_setclr_reg #(
            .W         (PORT_W),
            .RST_VAL   ((i == SC_FUNC) ? {PORT_W{1'b1}} : {PORT_W{1'b0}}),
            .HAS_ALIAS (1'b1)
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_base (hit_base),
            .wr_set  (hit_set),
            .wr_clr  (hit_clr),
            .wdata   (bus_wdata),
            .q       (sc_q[i])
        );
    end

    // Plain read/write words without aliases.
    for (genvar j = 0; j < NUM_PL; j++) begin : g_pl
        logic hit_base;
        always_comb hit_base = wr_ok && (int'(word) == PL_BASE[j]);
        gpio_setclr_reg #(
            .W         (PORT_W),
            .RST_VAL   ({PORT_W{1'b0}}),
            .HAS_ALIAS (1'b0)
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_base (hit_base),
            .wr_set  (1'b0),
            .wr_clr  (1'b0),
            .wdata   (bus_wdata),
            .q       (pl_q[j])
        );
    end

    gpio_pin_sync #(.W(PORT_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_q)
    );

    // Flag clear strobe decode.
    always_comb flag_clr_wr = wr_ok && (int'(word) == IDX_FLAGCLR);

    gpio_irq_flags #(.W(PORT_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (irq_hit),
        .clr_wr (flag_clr_wr),
        .wdata  (bus_wdata),
        .flags  (flags_q)
    );

    gpio_read_mux #(.WORD_W(WORD_W)) u_rmux (
        .aligned (aligned),
        .word    (word),
        .sc_q    (sc_q),
        .pl_q    (pl_q),
        .pin_q   (pin_q),
        .flags   (flags_q),
        .rdata   (bus_rdata)
    );

    // Parallel control outputs.
    always_comb begin
        func_en   = sc_q[SC_FUNC];
        out_en    = sc_q[SC_OE];
        out_val   = sc_q[SC_OUT];
        int_en    = sc_q[SC_IEN];
        wake_en   = sc_q[SC_WAKE];
        alt1_sel  = sc_q[SC_ALT1];
        alt2_sel  = sc_q[SC_ALT2];
        int_mode  = pl_q[PL_MODE];
        int_pol   = pl_q[PL_POL];
        in_en     = pl_q[PL_INEN];
        int_dual  = pl_q[PL_DUAL];
        int_flags = flags_q;
    end

    // Pad-setting words packed in address order.
    for (genvar k = 0; k < NUM_PAD; k++) begin : g_pad
        assign pad_cfg[k*32 +: 32] = pl_q[PL_PAD0 + k];
    end
endmodule

// File: rtl/gpio_port_regs_chk.sv
// Module: assertion checker for the GPIO port register bank, bound to the top.
// Assumes the default address map; watches ports only.
module gpio_port_regs_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       pin_in,
    input logic [31:0]       irq_hit,
    input logic [31:0]       out_en,
    input logic [31:0]       out_val,
    input logic [31:0]       int_flags
);
    logic [1:0] age;

    // Cycles since reset release, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    AST_OE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h10)) |=> (out_en == ($past(out_en) | $past(bus_wdata)))); // R3
    AST_OE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h14)) |=> (out_en == ($past(out_en) & ~$past(bus_wdata)))); // R4
    AST_ALIAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'('h1C)) |-> (bus_rdata == out_val)); // R5
    AST_PIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && bus_addr == ADDR_W'('h24)) |-> (bus_rdata == $past(pin_in, 2))); // R6
    AST_FLAG_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((int_flags & $past(irq_hit)) == $past(irq_hit))); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'('h48)) |=> ((int_flags & $past(int_flags)) == $past(int_flags))); // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'('h44) || bus_addr == ADDR_W'('h58)) |-> (bus_rdata == 32'h0)); // R9
    AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h38)) |=> $stable(out_en)); // R10
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .irq_hit   (irq_hit),
    .out_en    (out_en),
    .out_val   (out_val),
    .int_flags (int_flags)
);

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] irq_hit = '0;
    logic [31:0] func_en, alt1_sel, alt2_sel, out_en, out_val;
    logic [31:0] int_mode, int_pol, int_dual, in_en, int_en, wake_en, int_flags;
    logic [255:0] pad_cfg;

    int n_tests = 0;
    int n_fail  = 0;

    // Expected state, kept from the requirements.
    int          sc_base [7]  = '{0, 3, 6, 13, 19, 26, 29};
    int          pl_base [12] = '{10, 11, 12, 23, 24, 25, 42, 43, 44, 45, 46, 48};
    logic [31:0] sc_m [7];
    logic [31:0] pl_m [12];
    logic [31:0] flags_m;
    logic [31:0] pin_m;

    always #4 clk = ~clk;

    gpio_port_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .irq_hit(irq_hit), .func_en(func_en), .alt1_sel(alt1_sel),
        .alt2_sel(alt2_sel), .out_en(out_en), .out_val(out_val),
        .int_mode(int_mode), .int_pol(int_pol), .int_dual(int_dual),
        .in_en(in_en), .int_en(int_en), .wake_en(wake_en),
        .int_flags(int_flags), .pad_cfg(pad_cfg)
    );

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] a);
        int w;
        logic [31:0] r;
        r = '0;
        if (a[1:0] == 2'b00) begin
            w = int'(a[7:2]);
            for (int i = 0; i < 7; i++)
                if (w >= sc_base[i] && w <= sc_base[i] + 2) r = sc_m[i];
            for (int j = 0; j < 12; j++)
                if (w == pl_base[j]) r = pl_m[j];
            if (w == 9) r = pin_m;
            if (w == 16 || w == 18) r = flags_m;
        end
        return r;
    endfunction

    function automatic void model_write(logic [7:0] a, logic [31:0] d);
        int w;
        if (a[1:0] != 2'b00) return;
        w = int'(a[7:2]);
        for (int i = 0; i < 7; i++) begin
            if (w == sc_base[i])     sc_m[i] = d;
            if (w == sc_base[i] + 1) sc_m[i] = sc_m[i] | d;
            if (w == sc_base[i] + 2) sc_m[i] = sc_m[i] & ~d;
        end
        for (int j = 0; j < 12; j++)
            if (w == pl_base[j]) pl_m[j] = d;
        if (w == 18) flags_m = flags_m & ~d;
    endfunction

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(string req, logic [7:0] a);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, {224'h0, bus_rdata}, {224'h0, exp_read(a)});
    endtask

    task automatic check_outputs(string req);
        logic [255:0] pad_e;
        for (int k = 0; k < 8; k++) pad_e[k*32 +: 32] = pl_m[4 + k];
        check(req, {func_en, out_en, out_val, int_en, wake_en, alt1_sel, alt2_sel, int_mode},
                   {sc_m[0], sc_m[1], sc_m[2], sc_m[3], sc_m[4], sc_m[5], sc_m[6], pl_m[0]});
        check(req, {128'h0, int_pol, in_en, int_dual, int_flags},
                   {128'h0, pl_m[1], pl_m[2], pl_m[3], flags_m});
        check(req, pad_cfg, pad_e);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  a;
        logic [31:0] d;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 7; i++)  sc_m[i] = (i == 0) ? 32'hFFFF_FFFF : 32'h0;
        for (int j = 0; j < 12; j++) pl_m[j] = 32'h0;
        flags_m = '0; pin_m = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        #1 check("R1", {224'h0, func_en}, {224'h0, 32'hFFFF_FFFF});
        check_outputs("R1");
        rd("R1", 8'h34);

        // R2: base write and same-cycle readback
        wr(8'h18, 32'hA5A5_0F0F); rd("R2", 8'h18);
        wr(8'h00, 32'h0000_FFFF); rd("R2", 8'h00);
        // R3: set alias on output value and wake enable
        wr(8'h1C, 32'hF000_0001); rd("R3", 8'h18);
        wr(8'h50, 32'h0000_0081); rd("R3", 8'h4C);
        // R4: clear alias on function enable
        wr(8'h08, 32'h0000_00F0); rd("R4", 8'h00);
        // R5: alias reads
        rd("R5", 8'h1C); rd("R5", 8'h20); rd("R5", 8'h08);
        // R8: plain words and pad ordering
        wr(8'h60, 32'h1111_1111); wr(8'hC0, 32'hCCCC_0000); wr(8'hB0, 32'h0B0B_0B0B);
        wr(8'h2C, 32'h0000_2C2C);
        rd("R8", 8'h60); rd("R8", 8'hC0);
        check_outputs("R8");
        // R9: holes and misaligned accesses
        wr(8'h44, 32'hFFFF_FFFF); wr(8'h81, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
        wr(8'h19, 32'h0);
        rd("R9", 8'h44); rd("R9", 8'hBC); rd("R9", 8'h1A); rd("R9", 8'h18);
        check_outputs("R9");

        // R6: two-edge pin latency; write to pin word ignored
        @(negedge clk);
        pin_in = 32'hDEAD_BEEF; bus_addr = 8'h24;
        #1 check("R6", {224'h0, bus_rdata}, 256'h0);
        @(negedge clk);
        #1 check("R6", {224'h0, bus_rdata}, 256'h0);
        @(negedge clk);
        pin_m = 32'hDEAD_BEEF;
        #1 check("R6", {224'h0, bus_rdata}, {224'h0, 32'hDEAD_BEEF});
        wr(8'h24, 32'h0); rd("R6", 8'h24);

        // R7: flags set, sticky, cleared, hit wins, write to 0x40 ignored
        @(negedge clk) irq_hit = 32'h0000_0F03;
        @(negedge clk) irq_hit = 32'h0;
        flags_m = 32'h0000_0F03;
        rd("R7", 8'h40);
        wr(8'h40, 32'hFFFF_FFFF); rd("R7", 8'h40);
        wr(8'h48, 32'h0000_0101); rd("R7", 8'h48);
        @(negedge clk);
        bus_addr = 8'h48; bus_wr = 1'b1; bus_wdata = 32'h0000_0E02; irq_hit = 32'h0000_0002;
        @(negedge clk);
        bus_wr = 1'b0; irq_hit = 32'h0;
        flags_m = 32'h0000_0002;
        rd("R7", 8'h40);

        // R10: random traffic with isolation of every output
        for (int n = 0; n < 600; n++) begin
            if ($urandom % 8 == 0) a = 8'($urandom);
            else                   a = {6'($urandom % 52), 2'b00};
            case ($urandom % 3)
                0:       d = $urandom;
                1:       d = 32'h1 << ($urandom % 32);
                default: d = ~(32'h1 << ($urandom % 32));
            endcase
            wr(a, d);
            rd("R10", 8'({6'($urandom % 52), 2'b00}));
            if (n % 50 == 0) check_outputs("R10");
        end
        check_outputs("R10");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule